// File: doc/BRIEF.md
# Register-Driven Cache-Line Stream Copier

This unit sits beside a cache controller and lets software copy one 32-byte line from one physical address to another. The line passes through four 64-bit staging registers. Software either loads them directly with stores, or writes a source address, which pulls the whole line from memory into them. Writing a destination address then pushes the four staging words back out to memory. A transfer starts as a side effect of the address write; there is no separate start bit.

Beside the staging path, the unit holds a control register, an error register and a port-identity register. The control register is reachable both as a 64-bit value and through a 32-bit window onto its low half. The port-identity register resets to a value derived from a static CPU number. Memory traffic leaves through a simple 64-bit master port that moves one word per beat and waits on a ready signal. While a line transfer runs, the register port is stalled.

Top module: `lsc_line_copier`

## Requirements
- R1: A 64-bit write (reg_size64=1) to offset 0x000, 0x008, 0x010 or 0x018 loads staging word 0, 1, 2 or 3 with {reg_wdata_hi, reg_wdata_lo}, with the first word (reg_wdata_hi) in bits 63:32.
- R2: A 64-bit write to offset 0x100 starts a line fill: four read beats (mem_we=0) at base+0, +8, +16, +24, whose returned data lands in staging words 0..3 in that order.
- R3: A 64-bit write to offset 0x200 starts a line drain: four write beats (mem_we=1) at base+0, +8, +16, +24 that carry staging words 0..3.
- R4: The transfer base is reg_wdata_lo alone. reg_wdata_hi has no effect on addressing, and beat addresses wrap modulo 2^32.
- R5: Offset 0xA00 reads and writes the 64-bit control register. A 32-bit access (reg_size64=0) at 0xA04 reads the low half into rd_data[31:0] with zeros above it, and a 32-bit write there replaces only the low half, with reg_wdata_hi, leaving bits 63:32 as they were.
- R6: The 64-bit port-identity register at 0xF00 resets to ((cpu_id + 8) mod 16) << 24 and is readable and writable as 64 bits.
- R7: Offset 0xE00 is a 64-bit error register that reads back what was written and starts no memory traffic.
- R8: An access whose size differs from the register's size, or which goes to an unmapped offset, changes no state and starts no transfer, and a read of it returns zero. Source, destination and staging offsets count as write-only and read zero.
- R9: From the cycle after a fill or drain is accepted until the fourth beat completes, busy is 1 and reg_ready is 0, so no register access is accepted. With memory always ready, busy lasts exactly four cycles.
- R10: Beats go strictly in ascending address order. Address and direction hold while mem_ready is 0, and a beat completes only on a cycle with mem_req and mem_ready both 1.
- R11: An accepted read (reg_valid and reg_ready with reg_write=0) gives rd_valid=1 with rd_data on the following cycle, and only then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_id | input | 4 | Static CPU number for the port-identity reset value |
| reg_valid | input | 1 | Register access request |
| reg_ready | output | 1 | Access accepted this cycle when high together with reg_valid |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_size64 | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| reg_offset | input | 12 | Register offset |
| reg_wdata_hi | input | 32 | First write word (upper half of a 64-bit value) |
| reg_wdata_lo | input | 32 | Second write word (lower half) |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 64 | Read data |
| busy | output | 1 | Line transfer in progress |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | 32 | Beat byte address |
| mem_wdata | output | 64 | Write beat data |
| mem_rdata | input | 64 | Read beat data, valid with mem_ready |
| mem_ready | input | 1 | Memory completes the current beat |

## Verification
The hardest case to reach is a register access that arrives while a slow transfer is still running. The access has to stay pending across several stalled cycles and then be taken exactly once, with no early read response. The bench gets there by throttling mem_ready to one cycle in three, and it raises a control read just after a fill starts. It then holds the request until reg_ready returns and watches that rd_valid stays low in the meantime. Address wrap-around is reached by placing source lines at the top of the 32-bit space. Every offset at both sizes is read back against an arithmetic model of the register file.

// File: rtl/lsc_pkg.sv
// Shared definitions for the line copier: register offsets, transfer state,
// decoded register hit vector. Offsets are fixed by software convention.
package lsc_pkg;
    localparam int OFFS_W = 12;

    localparam logic [OFFS_W-1:0] OFF_SRC      = 12'h100;
    localparam logic [OFFS_W-1:0] OFF_DST      = 12'h200;
    localparam logic [OFFS_W-1:0] OFF_CTL_FULL = 12'hA00;
    localparam logic [OFFS_W-1:0] OFF_CTL_LOW  = 12'hA04;
    localparam logic [OFFS_W-1:0] OFF_ERR      = 12'hE00;
    localparam logic [OFFS_W-1:0] OFF_PORT     = 12'hF00;

    typedef enum logic [1:0] {
        XF_IDLE  = 2'd0,
        XF_FILL  = 2'd1,
        XF_DRAIN = 2'd2
    } xfer_e;

    typedef struct packed {
        logic stage;
        logic src;
        logic dst;
        logic ctl_full;
        logic ctl_low;
        logic err;
        logic port;
    } reg_hit_t;
endpackage

// File: rtl/lsc_reg_decode.sv
// Register decoder. Turns an offset and access size into a hit vector in
// which only size-legal hits are set; a mismatched size or an unmapped
// offset yields no hit at all. Assumes DATA_W/8 and BEATS are powers of two.
module lsc_reg_decode
    import lsc_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int BEATS  = 4
) (
    input  logic [OFFS_W-1:0]          offset,
    input  logic                       size64,
    output reg_hit_t                   hit,
    output logic [$clog2(BEATS)-1:0]   stage_idx
);
    localparam int STEP_SH    = $clog2(DATA_W / 8);
    localparam int BEAT_W     = $clog2(BEATS);
    localparam int STAGE_SPAN = BEATS << STEP_SH;

    // Size-qualified offset match for every mapped register.
    always_comb begin
        hit       = '0;
        stage_idx = offset[STEP_SH +: BEAT_W];
        if (size64) begin
            hit.stage    = (int'(offset) < STAGE_SPAN) && (offset[STEP_SH-1:0] == '0);
            hit.src      = (offset == OFF_SRC);
            hit.dst      = (offset == OFF_DST);
            hit.ctl_full = (offset == OFF_CTL_FULL);
            hit.err      = (offset == OFF_ERR);
            hit.port     = (offset == OFF_PORT);
        end else begin
            hit.ctl_low  = (offset == OFF_CTL_LOW);
        end
    end
endmodule

// File: rtl/lsc_stage_bank.sv
// Staging word bank. Holds BEATS data words, written either by the register
// port or by a fill beat, and exposes one word for a drain beat. Assumes the
// two write sources never act together (the port stalls during transfers);
// a fill still wins if they did.
module lsc_stage_bank #(
    parameter int DATA_W = 64,
    parameter int BEATS  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cpu_we,
    input  logic [$clog2(BEATS)-1:0]  cpu_idx,
    input  logic [DATA_W-1:0]         cpu_data,
    input  logic                      fill_we,
    input  logic [$clog2(BEATS)-1:0]  fill_idx,
    input  logic [DATA_W-1:0]         fill_data,
    input  logic [$clog2(BEATS)-1:0]  rd_idx,
    output logic [DATA_W-1:0]         rd_word
);
    localparam int BEAT_W = $clog2(BEATS);

    logic [DATA_W-1:0] stage_q [BEATS];

    for (genvar g = 0; g < BEATS; g++) begin : g_word
        // One staging word: fill beat first, then direct store.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q[g] <= '0;
            end else if (fill_we && (fill_idx == BEAT_W'(g))) begin
                stage_q[g] <= fill_data;
            end else if (cpu_we && (cpu_idx == BEAT_W'(g))) begin
                stage_q[g] <= cpu_data;
            end
        end
    end

    // Word presented to the memory port during a drain.
    assign rd_word = stage_q[rd_idx];
endmodule

// File: rtl/lsc_beat_engine.sv
// Line transfer sequencer. On a start pulse it latches the base address and
// walks BEATS beats in ascending order, holding each beat until mem_ready.
// Assumes starts arrive only while idle.
module lsc_beat_engine
    import lsc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int BEATS  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_fill,
    input  logic                      start_drain,
    input  logic [ADDR_W-1:0]         start_addr,
    input  logic                      mem_ready,
    output logic                      mem_req,
    output logic                      mem_we,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic [$clog2(BEATS)-1:0]  beat_idx,
    output logic                      fill_we
);
    localparam int                 STEP_SH = $clog2(DATA_W / 8);
    localparam int                 BEAT_W  = $clog2(BEATS);
    localparam logic [BEAT_W-1:0]  LAST    = BEAT_W'(BEATS - 1);

    xfer_e               state_q;
    logic [BEAT_W-1:0]   beat_q;
    logic [ADDR_W-1:0]   base_q;

    // Transfer state, beat counter and latched base address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= XF_IDLE;
            beat_q  <= '0;
            base_q  <= '0;
        end else begin
            case (state_q)
                XF_IDLE: begin
                    beat_q <= '0;
                    if (start_fill) begin
                        state_q <= XF_FILL;
                        base_q  <= start_addr;
                    end else if (start_drain) begin
                        state_q <= XF_DRAIN;
                        base_q  <= start_addr;
                    end
                end
                XF_FILL, XF_DRAIN: begin
                    if (mem_ready) begin
                        if (beat_q == LAST) begin
                            state_q <= XF_IDLE;
                            beat_q  <= '0;
                        end else begin
                            beat_q <= beat_q + BEAT_W'(1);
                        end
                    end
                end
                default: state_q <= XF_IDLE;
            endcase
        end
    end

    // Beat request, direction and address derived from the state.
    always_comb begin
        mem_req  = (state_q != XF_IDLE);
        mem_we   = (state_q == XF_DRAIN);
        mem_addr = base_q + (ADDR_W'(beat_q) << STEP_SH);
        fill_we  = (state_q == XF_FILL) && mem_ready;
        beat_idx = beat_q;
    end
endmodule

// File: rtl/lsc_line_copier.sv
// Line copier top. Decodes register accesses, holds the control, error and
// port-identity registers, and ties the staging bank to the beat engine.
// Writing the source or destination offset starts a fill or a drain; the
// register port stalls until the last beat completes. Assumes cpu_id is
// static while out of reset.
module lsc_line_copier
    import lsc_pkg::*;
#(
    parameter int DATA_W     = 64,
    parameter int ADDR_W     = 32,
    parameter int BEATS      = 4,
    parameter int ID_W       = 4,
    parameter int PORT_SHIFT = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ID_W-1:0]      cpu_id,
    input  logic                 reg_valid,
    output logic                 reg_ready,
    input  logic                 reg_write,
    input  logic                 reg_size64,
    input  logic [OFFS_W-1:0]    reg_offset,
    input  logic [DATA_W/2-1:0]  reg_wdata_hi,
    input  logic [DATA_W/2-1:0]  reg_wdata_lo,
    output logic                 rd_valid,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 busy,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [DATA_W-1:0]    mem_wdata,
    input  logic [DATA_W-1:0]    mem_rdata,
    input  logic                 mem_ready
);
    localparam int HALF_W  = DATA_W / 2;
    localparam int BEAT_W  = $clog2(BEATS);
    localparam int ID_BIAS = 1 << (ID_W - 1);

    reg_hit_t            hit;
    logic [BEAT_W-1:0]   stage_idx;
    logic [BEAT_W-1:0]   beat_idx;
    logic                fill_we;
    logic                acc, wr_acc, rd_acc;
    logic [DATA_W-1:0]   wr_word;
    logic [DATA_W-1:0]   ctl_q, err_q, port_q;
    logic [DATA_W-1:0]   rd_next;
    logic [ID_W-1:0]     id_sum;
    logic [DATA_W-1:0]   port_reset;

    // Access qualification and 64-bit write word assembly.
    always_comb begin
        reg_ready  = !busy;
        acc        = reg_valid && reg_ready;
        wr_acc     = acc && reg_write;
        rd_acc     = acc && !reg_write;
        wr_word    = {reg_wdata_hi, reg_wdata_lo};
        id_sum     = cpu_id + ID_W'(ID_BIAS);
        port_reset = DATA_W'(id_sum) << PORT_SHIFT;
    end

    lsc_reg_decode #(
        .DATA_W (DATA_W),
        .BEATS  (BEATS)
    ) u_decode (
        .offset    (reg_offset),
        .size64    (reg_size64),
        .hit       (hit),
        .stage_idx (stage_idx)
    );

    lsc_beat_engine #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .BEATS  (BEATS)
    ) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_fill  (wr_acc && hit.src),
        .start_drain (wr_acc && hit.dst),
        .start_addr  (reg_wdata_lo[ADDR_W-1:0]),
        .mem_ready   (mem_ready),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .beat_idx    (beat_idx),
        .fill_we     (fill_we)
    );

    assign busy = mem_req;

    lsc_stage_bank #(
        .DATA_W (DATA_W),
        .BEATS  (BEATS)
    ) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_we    (wr_acc && hit.stage),
        .cpu_idx   (stage_idx),
        .cpu_data  (wr_word),
        .fill_we   (fill_we),
        .fill_idx  (beat_idx),
        .fill_data (mem_rdata),
        .rd_idx    (beat_idx),
        .rd_word   (mem_wdata)
    );

    // Control register: full-width write or low-half window write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr_acc && hit.ctl_full) begin
            ctl_q <= wr_word;
        end else if (wr_acc && hit.ctl_low) begin
            ctl_q <= {ctl_q[DATA_W-1:HALF_W], reg_wdata_hi};
        end
    end

    // Error register: plain storage, no side effects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= '0;
        end else if (wr_acc && hit.err) begin
            err_q <= wr_word;
        end
    end

    // Port-identity register: reset value from the CPU number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_q <= port_reset;
        end else if (wr_acc && hit.port) begin
            port_q <= wr_word;
        end
    end

    // Read multiplexer; everything not readable returns zero.
    always_comb begin
        rd_next = '0;
        if (hit.ctl_full) rd_next = ctl_q;
        if (hit.ctl_low)  rd_next = {{HALF_W{1'b0}}, ctl_q[HALF_W-1:0]};
        if (hit.err)      rd_next = err_q;
        if (hit.port)     rd_next = port_q;
    end

    // Registered read response, one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_acc;
            if (rd_acc) begin
                rd_data <= rd_next;
            end
        end
    end
endmodule

// File: rtl/lsc_checker.sv
// Protocol checker for the line copier, attached by bind. Tracks completed
// beats per transfer with its own counter and checks stalls, start beats,
// beat ordering and read response timing.
module lsc_checker
    import lsc_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 32,
    parameter int BEATS  = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_valid,
    input logic                 reg_ready,
    input logic                 reg_write,
    input logic                 reg_size64,
    input logic [OFFS_W-1:0]    reg_offset,
    input logic [DATA_W/2-1:0]  reg_wdata_lo,
    input logic                 rd_valid,
    input logic                 busy,
    input logic                 mem_req,
    input logic                 mem_we,
    input logic [ADDR_W-1:0]    mem_addr,
    input logic                 mem_ready
);
    localparam int                BEAT_W = $clog2(BEATS);
    localparam logic [BEAT_W-1:0] LAST   = BEAT_W'(BEATS - 1);

    logic [BEAT_W-1:0] done_cnt;

    // Completed beats within the current transfer.
    always_ff @(posedge clk) begin
        if (!rst_n || !mem_req) begin
            done_cnt <= '0;
        end else if (mem_ready) begin
            done_cnt <= done_cnt + BEAT_W'(1);
        end
    end

    logic wr_acc;
    assign wr_acc = reg_valid && reg_ready && reg_write;

    // R9: no access is accepted during a transfer
    p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !reg_ready);

    // R9: the transfer ends right after the last beat
    p_end_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && done_cnt == LAST) |=> !mem_req);

    // R2 and R4: fill starts with a read beat at the low word
    p_fill_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && reg_size64 && reg_offset == OFF_SRC) |=>
        (mem_req && !mem_we && mem_addr == $past(reg_wdata_lo[ADDR_W-1:0])));

    // R3 and R4: drain starts with a write beat at the low word
    p_drain_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && reg_size64 && reg_offset == OFF_DST) |=>
        (mem_req && mem_we && mem_addr == $past(reg_wdata_lo[ADDR_W-1:0])));

    // R8: a 32-bit write to a start offset starts nothing
    p_badsize_no_xfer_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && !reg_size64 && (reg_offset == OFF_SRC || reg_offset == OFF_DST)) |=> !mem_req);

    // R10: a waiting beat holds its address and direction
    p_hold_beat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R10: the next beat is one word higher
    p_ascend_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && done_cnt != LAST) |=>
        (mem_req && mem_addr == $past(mem_addr) + ADDR_W'(DATA_W / 8)));

    // R11: read response only after an accepted read
    p_rd_resp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(reg_valid && reg_ready && !reg_write));
endmodule

bind lsc_line_copier lsc_checker #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .BEATS  (BEATS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_valid    (reg_valid),
    .reg_ready    (reg_ready),
    .reg_write    (reg_write),
    .reg_size64   (reg_size64),
    .reg_offset   (reg_offset),
    .reg_wdata_lo (reg_wdata_lo),
    .rd_valid     (rd_valid),
    .busy         (busy),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_ready    (mem_ready)
);

// File: tb/lsc_line_copier_tb.sv
module lsc_line_copier_tb;
    localparam int         CLK_PERIOD = 10;
    localparam logic [3:0] CPU_ID     = 4'd9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_valid = 1'b0, reg_write = 1'b0, reg_size64 = 1'b0;
    logic [11:0] reg_offset = '0;
    logic [31:0] reg_wdata_hi = '0, reg_wdata_lo = '0;
    logic        reg_ready, rd_valid, busy, mem_req, mem_we;
    logic [63:0] rd_data, mem_wdata, mem_rdata;
    logic [31:0] mem_addr;
    logic        mem_ready = 1'b1;

    int checks = 0, fails = 0, cyc = 0, ready_mode = 0, log_n = 0;
    bit finished = 0;
    logic [31:0] log_addr [16];
    logic        log_we   [16];
    logic [63:0] log_data [16];
    logic [63:0] exp_stage [4];
    logic [63:0] exp_ctl = '0, exp_err = '0, exp_port = '0;

    lsc_line_copier u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_id(CPU_ID),
        .reg_valid(reg_valid), .reg_ready(reg_ready), .reg_write(reg_write),
        .reg_size64(reg_size64), .reg_offset(reg_offset),
        .reg_wdata_hi(reg_wdata_hi), .reg_wdata_lo(reg_wdata_lo),
        .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Memory model: read data is a pure function of the address.
    function automatic logic [63:0] pat(input logic [31:0] a);
        return {a ^ 32'h5A5A_C3C3, a + 32'h1111_0000};
    endfunction
    assign mem_rdata = pat(mem_addr);

    // Ready pattern: always, or one cycle in three.
    always @(negedge clk) begin
        cyc = cyc + 1;
        mem_ready = (ready_mode == 0) ? 1'b1 : ((cyc % 3) == 0);
    end

    // Beat log.
    always @(posedge clk) begin
        if (rst_n && mem_req && mem_ready && log_n < 16) begin
            log_addr[log_n] <= mem_addr;
            log_we[log_n]   <= mem_we;
            log_data[log_n] <= mem_we ? mem_wdata : mem_rdata;
            log_n           <= log_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_op(input bit wr, input logic [11:0] off, input bit sz,
                          input logic [31:0] hi, input logic [31:0] lo, output logic [63:0] rdat);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = wr; reg_size64 = sz;
        reg_offset = off; reg_wdata_hi = hi; reg_wdata_lo = lo;
        while (!reg_ready) @(negedge clk);
        @(negedge clk);
        reg_valid = 1'b0;
        rdat = rd_data;
        if (!wr) check(rd_valid === 1'b1, "R11 rd_valid after read", 64'(rd_valid), 64'd1);
    endtask

    function automatic logic [63:0] exp_read(input logic [11:0] off, input bit sz);
        if (sz && off == 12'hA00) return exp_ctl;
        if (!sz && off == 12'hA04) return {32'd0, exp_ctl[31:0]};
        if (sz && off == 12'hE00) return exp_err;
        if (sz && off == 12'hF00) return exp_port;
        return 64'd0;
    endfunction

    task automatic do_fill(input logic [31:0] hi, input logic [31:0] base, input int mode);
        logic [63:0] d;
        int cnt;
        ready_mode = mode;
        log_n = 0;
        reg_op(1'b1, 12'h100, 1'b1, hi, base, d);
        cnt = 0;
        while (busy) begin cnt++; @(negedge clk); end
        if (mode == 0) check(cnt == 4, "R9 busy cycles fill", 64'(cnt), 64'd4);
        check(log_n == 4, "R2 fill beat count", 64'(log_n), 64'd4);
        for (int i = 0; i < 4; i++) begin
            check(log_addr[i] === base + 32'(8*i) && log_we[i] === 1'b0,
                  "R2 R4 R10 fill beat address", 64'(log_addr[i]), 64'(base + 32'(8*i)));
            exp_stage[i] = pat(base + 32'(8*i));
        end
    endtask

    task automatic do_drain(input logic [31:0] hi, input logic [31:0] base, input int mode, input string req);
        logic [63:0] d;
        ready_mode = mode;
        log_n = 0;
        reg_op(1'b1, 12'h200, 1'b1, hi, base, d);
        while (busy) @(negedge clk);
        check(log_n == 4, "R3 drain beat count", 64'(log_n), 64'd4);
        for (int i = 0; i < 4; i++) begin
            check(log_addr[i] === base + 32'(8*i) && log_we[i] === 1'b1,
                  "R3 R4 R10 drain beat address", 64'(log_addr[i]), 64'(base + 32'(8*i)));
            check(log_data[i] === exp_stage[i], req, log_data[i], exp_stage[i]);
        end
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] d;
        int bad;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(reg_ready === 1'b1 && busy === 1'b0 && mem_req === 1'b0 && rd_valid === 1'b0,
              "R9 idle after reset", {reg_ready, busy, mem_req, rd_valid}, 64'h8);

        // R6: port identity reset value ((9+8) mod 16) << 24
        exp_port = 64'h0000_0000_0100_0000;
        reg_op(1'b0, 12'hF00, 1'b1, 0, 0, d);
        check(d === exp_port, "R6 port reset value", d, exp_port);

        // R5: control full and low-half window
        reg_op(1'b1, 12'hA00, 1'b1, 32'h1122_3344, 32'h5566_7788, d);
        exp_ctl = 64'h1122_3344_5566_7788;
        reg_op(1'b0, 12'hA00, 1'b1, 0, 0, d);
        check(d === exp_ctl, "R5 control full read", d, exp_ctl);
        reg_op(1'b0, 12'hA04, 1'b0, 0, 0, d);
        check(d === 64'h5566_7788, "R5 control low read", d, 64'h5566_7788);
        reg_op(1'b1, 12'hA04, 1'b0, 32'hCAFE_F00D, 32'hFFFF_FFFF, d);
        exp_ctl = 64'h1122_3344_CAFE_F00D;
        reg_op(1'b0, 12'hA00, 1'b1, 0, 0, d);
        check(d === exp_ctl, "R5 low write keeps upper half", d, exp_ctl);

        // R7: error register, no side effect
        reg_op(1'b1, 12'hE00, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, d);
        exp_err = '1;
        check(mem_req === 1'b0 && busy === 1'b0, "R7 error write starts nothing", 64'(mem_req), 64'd0);
        reg_op(1'b0, 12'hE00, 1'b1, 0, 0, d);
        check(d === exp_err, "R7 error readback", d, exp_err);

        // R6: port identity writable
        reg_op(1'b1, 12'hF00, 1'b1, 32'h0000_00AB, 32'h0300_0000, d);
        exp_port = 64'h0000_00AB_0300_0000;
        reg_op(1'b0, 12'hF00, 1'b1, 0, 0, d);
        check(d === exp_port, "R6 port write", d, exp_port);

        // R8: mismatched sizes and unmapped offsets change nothing
        reg_op(1'b1, 12'hA00, 1'b0, 32'hDEAD_BEEF, 32'hDEAD_BEEF, d);
        reg_op(1'b1, 12'hA04, 1'b1, 32'hDEAD_BEEF, 32'hDEAD_BEEF, d);
        reg_op(1'b1, 12'hE00, 1'b0, 32'hDEAD_BEEF, 32'hDEAD_BEEF, d);
        reg_op(1'b1, 12'hF00, 1'b0, 32'hDEAD_BEEF, 32'hDEAD_BEEF, d);
        reg_op(1'b1, 12'h300, 1'b1, 32'hDEAD_BEEF, 32'hDEAD_BEEF, d);
        reg_op(1'b1, 12'h100, 1'b0, 32'hDEAD_BEEF, 32'h0000_1000, d);
        check(mem_req === 1'b0 && busy === 1'b0, "R8 short source write starts nothing", 64'(mem_req), 64'd0);
        reg_op(1'b1, 12'h200, 1'b0, 32'hDEAD_BEEF, 32'h0000_1000, d);
        check(mem_req === 1'b0 && busy === 1'b0, "R8 short destination write starts nothing", 64'(mem_req), 64'd0);

        // R1: direct staging writes, observed through a drain
        for (int i = 0; i < 4; i++) begin
            reg_op(1'b1, 12'(8*i), 1'b1, 32'hA000_0000 + 32'(i), 32'h0B0B_0000 + 32'(7*i), d);
            exp_stage[i] = {32'hA000_0000 + 32'(i), 32'h0B0B_0000 + 32'(7*i)};
        end
        do_drain(32'h0, 32'h0000_1000, 0, "R1 R3 staging data on drain");

        // R8: short staging write and misaligned staging offset ignored
        reg_op(1'b1, 12'h008, 1'b0, 32'h1234_5678, 32'h1234_5678, d);
        reg_op(1'b1, 12'h004, 1'b1, 32'h1234_5678, 32'h1234_5678, d);
        reg_op(1'b1, 12'h020, 1'b1, 32'h1234_5678, 32'h1234_5678, d);
        do_drain(32'h0, 32'h0000_2000, 1, "R8 staging unchanged");

        // R2 R3 R4: fills and drains, upper word junk, wrap at the top
        do_fill(32'h0, 32'h0000_0040, 0);
        do_drain(32'hFFFF_FFFF, 32'h0000_8000, 1, "R2 R3 copied line");
        do_fill(32'hFFFF_FFFF, 32'h7FFF_FFE8, 1);
        do_drain(32'h1234_5678, 32'hFFFF_FFF8, 0, "R2 R4 copied line wrap");
        do_fill(32'h1234_5678, 32'hFFFF_FFF0, 0);
        do_drain(32'h0, 32'h0000_0000, 1, "R2 R4 fill wrap");

        // R9 R11: read held pending during a slow fill
        ready_mode = 1;
        log_n = 0;
        reg_op(1'b1, 12'h100, 1'b1, 32'h0, 32'h0000_0300, d);
        reg_valid = 1'b1; reg_write = 1'b0; reg_size64 = 1'b1; reg_offset = 12'hA00;
        bad = 0;
        check(reg_ready === 1'b0, "R9 ready low during fill", 64'(reg_ready), 64'd0);
        while (!reg_ready) begin
            if (rd_valid) bad++;
            @(negedge clk);
        end
        @(negedge clk);
        reg_valid = 1'b0;
        check(bad == 0, "R9 R11 no response while stalled", 64'(bad), 64'd0);
        check(rd_valid === 1'b1 && rd_data === exp_ctl, "R9 R11 pending read taken once", rd_data, exp_ctl);
        @(negedge clk);
        check(rd_valid === 1'b0, "R11 single response", 64'(rd_valid), 64'd0);
        check(log_n == 4, "R9 fill completed before read", 64'(log_n), 64'd4);
        ready_mode = 0;

        // R5 R6 R7 R8: read sweep over all offsets at both sizes
        for (int off = 0; off < 4096; off += 4) begin
            for (int sz = 0; sz < 2; sz++) begin
                reg_op(1'b0, 12'(off), sz[0], 0, 0, d);
                check(d === exp_read(12'(off), sz[0]), "R8 read sweep", d, exp_read(12'(off), sz[0]));
            end
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule